// File: doc/BRIEF.md
# Vector Atomic Instruction Decoder

This block sits in the decode stage of a vector-capable core. Each cycle it may be handed a 32-bit instruction word together with the vector configuration that is live at that moment. That configuration is the element width code, the register-group multiplier code, the vector-illegal flag, the 64-bit mode flag and the atomic-extension enable. The block finds the indexed vector atomic memory operations that share the standard atomic major opcode. It splits such an instruction into an operation index, a memory-width bit, the three register numbers and the write-back and mask flags.

Legality depends on the dynamic vector state as well as on the opcode bits. An instruction can be well formed and still be illegal under the current configuration. The block judges it against that configuration and raises an illegal flag. It also packs a descriptor word that the execution side reads. All results appear one cycle after the input strobe and stay unchanged until the next strobe.

Top module: `vec_atomic_decoder`

## Requirements
- R1: The word is recognised (is_vamo=1) only when bits [6:0] are 0101111, bits [14:12] are 110 or 111, and bits [31:27] hold one of the nine operation codes listed in R2. Any other word gives is_vamo=0, illegal=0, and zero on op_idx, mem_dw, vd, rs1, vs2, wd, vm and desc.
- R2: op_idx follows bits [31:27]: 00001→0 (swap), 00000→1 (add), 00100→2 (xor), 01100→3 (and), 01000→4 (or), 10000→5 (min), 10100→6 (max), 11000→7 (minu), 11100→8 (maxu).
- R3: mem_dw is 1 for width field 111 (64-bit memory element) and 0 for 110 (32-bit).
- R4: For a recognised word the fields are taken from these bits: vd from [11:7], rs1 from [19:15], vs2 from [24:20], vm from bit 25, wd from bit 26.
- R5: A recognised word is illegal when vill=1 or when atomic_en=0.
- R6: sew_log2 codes the element size as 8<<sew_log2 bits. A recognised word is illegal in any of these cases: sew_log2<2; sew_log2=3 while rv64_mode=0; mem_dw=1 while rv64_mode=0; mem_dw=1 while sew_log2=2.
- R7: A recognised word with wd=1, vm=0 and vd=0 is illegal. The same word with vm=1 or wd=0 is not made illegal by this rule.
- R8: With group size 2^lmul_log2, a recognised word is illegal when vd or vs2 is not a multiple of the group size.
- R9: For a recognised word, desc[7:0] = (8<<sew_log2)>>lmul_log2, desc[8]=vm, desc[10:9]=lmul_log2, desc[11]=wd and desc[31:12]=0.
- R10: out_valid is high exactly in the cycle after a cycle with in_valid high. The outputs change only on such a strobe. Reset clears out_valid and all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction and configuration are valid this cycle |
| insn | input | 32 | Instruction word |
| sew_log2 | input | 2 | Element width code, element = 8<<code bits |
| lmul_log2 | input | 2 | Register group code, group = 2^code registers |
| vill | input | 1 | Vector configuration is illegal |
| rv64_mode | input | 1 | 64-bit integer register width is active |
| atomic_en | input | 1 | Atomic extension is enabled |
| out_valid | output | 1 | Decoded results are valid |
| is_vamo | output | 1 | Word is a vector atomic operation |
| illegal | output | 1 | Recognised word is illegal under the current configuration |
| op_idx | output | 4 | Operation index 0..8 |
| mem_dw | output | 1 | Memory element is 64-bit |
| vd | output | 5 | Destination / source-data vector register |
| rs1 | output | 5 | Scalar base register |
| vs2 | output | 5 | Index vector register |
| wd | output | 1 | Old memory value is written back to vd |
| vm | output | 1 | Unmasked operation |
| desc | output | 32 | Packed descriptor word |

## Verification
The bench targets the legality boundaries: SEW of 16 against 32 bits, SEW of 64 in 32-bit mode, and 64-bit memory width against a 32-bit SEW. A decoder with an off-by-one compare would pass the illegal word or reject the legal one. It checks the mask-overlap rule, flipping wd, vm and vd one at a time. A decoder that tests only one of the three flags would flag legal words. It also tries group alignment at a multiplier of 4 on vd and vs2 separately, where a missed alignment check lets a bad register group through. It runs near-miss encodings and a few descriptor values at extreme multipliers. An unused funct5, a wrong width field and a wrong major opcode must all give is_vamo=0, and a wrongly shifted MLEN would show up in desc[7:0].

// File: rtl/vamo_dec_pkg.sv
// Shared constants and types for the vector atomic decoder.
// Assumes a 32-bit instruction word with the atomic major opcode in [6:0].
package vamo_dec_pkg;
    localparam int unsigned INSN_W  = 32;
    localparam int unsigned REG_W   = 5;
    localparam int unsigned OP_W    = 4;
    localparam int unsigned DESC_W  = 32;
    localparam int unsigned MLEN_W  = 8;
    localparam int unsigned CODE_W  = 2;
    localparam logic [6:0]  AMO_MAJOR  = 7'b0101111;
    localparam logic [2:0]  WIDTH_32B  = 3'b110;
    localparam logic [2:0]  WIDTH_64B  = 3'b111;

    typedef enum logic [OP_W-1:0] {
        OP_SWAP = 4'd0, OP_ADD = 4'd1, OP_XOR = 4'd2, OP_AND = 4'd3,
        OP_OR   = 4'd4, OP_MIN = 4'd5, OP_MAX = 4'd6, OP_MINU = 4'd7,
        OP_MAXU = 4'd8
    } vamo_op_e;

    typedef struct packed {
        logic             hit;
        vamo_op_e         op;
        logic             dw;
        logic [REG_W-1:0] vd;
        logic [REG_W-1:0] rs1;
        logic [REG_W-1:0] vs2;
        logic             wd;
        logic             vm;
    } vamo_fields_t;
endpackage

// File: rtl/vamo_field_split.sv
// Recognises a vector atomic encoding and splits the instruction into fields.
// Assumes the field positions fixed by the atomic major opcode layout.
module vamo_field_split
    import vamo_dec_pkg::*;
#(
    parameter int unsigned IW = INSN_W
) (
    input  logic [IW-1:0] insn,
    output vamo_fields_t  fld
);
    logic       major_ok;
    logic       width_ok;
    logic       op_known;
    vamo_op_e   op_sel;

    // Map the five operation bits to an operation index.
    always_comb begin
        op_known = 1'b1;
        op_sel   = OP_SWAP;
        unique case (insn[31:27])
            5'b00001: op_sel = OP_SWAP;
            5'b00000: op_sel = OP_ADD;
            5'b00100: op_sel = OP_XOR;
            5'b01100: op_sel = OP_AND;
            5'b01000: op_sel = OP_OR;
            5'b10000: op_sel = OP_MIN;
            5'b10100: op_sel = OP_MAX;
            5'b11000: op_sel = OP_MINU;
            5'b11100: op_sel = OP_MAXU;
            default:  op_known = 1'b0;
        endcase
    end

    assign major_ok = (insn[6:0] == AMO_MAJOR);
    assign width_ok = (insn[14:12] == WIDTH_32B) || (insn[14:12] == WIDTH_64B);

    // Gather the fields; all zero when the word is not a vector atomic.
    always_comb begin
        fld     = '0;
        fld.hit = major_ok && width_ok && op_known;
        if (fld.hit) begin
            fld.op  = op_sel;
            fld.dw  = insn[12];
            fld.vd  = insn[11:7];
            fld.rs1 = insn[19:15];
            fld.vs2 = insn[24:20];
            fld.vm  = insn[25];
            fld.wd  = insn[26];
        end
    end
endmodule

// File: rtl/vamo_legal_check.sv
// Judges a recognised vector atomic against the live vector configuration.
// Assumes sew/lmul are log2 codes; the output is only meaningful when hit=1.
module vamo_legal_check
    import vamo_dec_pkg::*;
#(
    parameter int unsigned RW = REG_W,
    parameter int unsigned CW = CODE_W
) (
    input  vamo_fields_t  fld,
    input  logic [CW-1:0] sew_log2,
    input  logic [CW-1:0] lmul_log2,
    input  logic          vill,
    input  logic          rv64_mode,
    input  logic          atomic_en,
    output logic          illegal
);
    localparam int unsigned NCHK = 2;
    localparam logic [CW-1:0] SEW_MIN = CW'(2);
    localparam logic [CW-1:0] SEW_64  = CW'(3);

    logic [RW-1:0]   grp_mask;
    logic [RW-1:0]   regs [NCHK];
    logic [NCHK-1:0] misalign;
    logic            cfg_bad, width_bad, overlap_bad;

    // Low bits that must be clear for a register group of 2^lmul.
    always_comb begin
        grp_mask = '0;
        for (int b = 0; b < int'(RW); b++) begin
            if (b < int'(lmul_log2)) grp_mask[b] = 1'b1;
        end
    end

    assign regs[0] = fld.vd;
    assign regs[1] = fld.vs2;

    genvar g;
    generate
        for (g = 0; g < int'(NCHK); g++) begin : g_align
            // Flag a vector register number that does not start a group.
            assign misalign[g] = |(regs[g] & grp_mask);
        end
    endgenerate

    assign cfg_bad     = vill || !atomic_en;
    assign width_bad   = (sew_log2 < SEW_MIN)
                      || ((sew_log2 == SEW_64) && !rv64_mode)
                      || (fld.dw && !rv64_mode)
                      || (fld.dw && (sew_log2 != SEW_64));
    assign overlap_bad = fld.wd && !fld.vm && (fld.vd == '0);
    assign illegal     = fld.hit && (cfg_bad || width_bad || overlap_bad || (|misalign));
endmodule

// File: rtl/vamo_desc_pack.sv
// Packs the descriptor word that accompanies a vector atomic to execution.
// Assumes MLEN = SEW bits divided by the group size, fitting in MW bits.
module vamo_desc_pack
    import vamo_dec_pkg::*;
#(
    parameter int unsigned DW = DESC_W,
    parameter int unsigned MW = MLEN_W,
    parameter int unsigned CW = CODE_W
) (
    input  logic          hit,
    input  logic [CW-1:0] sew_log2,
    input  logic [CW-1:0] lmul_log2,
    input  logic          vm,
    input  logic          wd,
    output logic [DW-1:0] desc
);
    localparam int unsigned VM_POS   = MW;
    localparam int unsigned LMUL_POS = MW + 1;
    localparam int unsigned WD_POS   = LMUL_POS + CW;

    logic [MW-1:0] mlen;

    assign mlen = (MW'(8) << sew_log2) >> lmul_log2;

    // Place each descriptor field; zero when not recognised.
    always_comb begin
        desc = '0;
        if (hit) begin
            desc[MW-1:0]                  = mlen;
            desc[VM_POS]                  = vm;
            desc[LMUL_POS +: CW]          = lmul_log2;
            desc[WD_POS]                  = wd;
        end
    end
endmodule

// File: rtl/vec_atomic_decoder.sv
// Top of the vector atomic decoder: combinational decode, one output register stage.
// Assumes inputs are sampled only when in_valid is high; results hold between strobes.
module vec_atomic_decoder
    import vamo_dec_pkg::*;
#(
    parameter int unsigned IW = INSN_W,
    parameter int unsigned RW = REG_W,
    parameter int unsigned OW = OP_W,
    parameter int unsigned DW = DESC_W,
    parameter int unsigned CW = CODE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [IW-1:0] insn,
    input  logic [CW-1:0] sew_log2,
    input  logic [CW-1:0] lmul_log2,
    input  logic          vill,
    input  logic          rv64_mode,
    input  logic          atomic_en,
    output logic          out_valid,
    output logic          is_vamo,
    output logic          illegal,
    output logic [OW-1:0] op_idx,
    output logic          mem_dw,
    output logic [RW-1:0] vd,
    output logic [RW-1:0] rs1,
    output logic [RW-1:0] vs2,
    output logic          wd,
    output logic          vm,
    output logic [DW-1:0] desc
);
    vamo_fields_t  fld;
    logic          ill_c;
    logic [DW-1:0] desc_c;

    vamo_field_split #(.IW(IW)) u_split (
        .insn (insn),
        .fld  (fld)
    );

    vamo_legal_check #(.RW(RW), .CW(CW)) u_legal (
        .fld       (fld),
        .sew_log2  (sew_log2),
        .lmul_log2 (lmul_log2),
        .vill      (vill),
        .rv64_mode (rv64_mode),
        .atomic_en (atomic_en),
        .illegal   (ill_c)
    );

    vamo_desc_pack #(.DW(DW), .CW(CW)) u_desc (
        .hit       (fld.hit),
        .sew_log2  (sew_log2),
        .lmul_log2 (lmul_log2),
        .vm        (fld.vm),
        .wd        (fld.wd),
        .desc      (desc_c)
    );

    // Strobe follows the input valid by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Capture decoded results on an input strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_vamo <= 1'b0;
            illegal <= 1'b0;
            op_idx  <= '0;
            mem_dw  <= 1'b0;
            vd      <= '0;
            rs1     <= '0;
            vs2     <= '0;
            wd      <= 1'b0;
            vm      <= 1'b0;
            desc    <= '0;
        end else if (in_valid) begin
            is_vamo <= fld.hit;
            illegal <= ill_c;
            op_idx  <= OW'(fld.op);
            mem_dw  <= fld.dw;
            vd      <= fld.vd;
            rs1     <= fld.rs1;
            vs2     <= fld.vs2;
            wd      <= fld.wd;
            vm      <= fld.vm;
            desc    <= desc_c;
        end
    end
endmodule

// File: rtl/vamo_dec_chk.sv
// Property checker for the vector atomic decoder, bound to the top module.
// Assumes the default parameter widths of the top.
module vamo_dec_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] insn,
    input logic [1:0]  sew_log2,
    input logic [1:0]  lmul_log2,
    input logic        vill,
    input logic        rv64_mode,
    input logic        atomic_en,
    input logic        out_valid,
    input logic        is_vamo,
    input logic        illegal,
    input logic [3:0]  op_idx,
    input logic        mem_dw,
    input logic [4:0]  vd,
    input logic [4:0]  rs1,
    input logic [4:0]  vs2,
    input logic        wd,
    input logic        vm,
    input logic [31:0] desc
);
    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R10
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(desc) && $stable(illegal));
    // R1
    illegal_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> is_vamo);
    // R2
    op_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_vamo |-> op_idx <= 4'd8);
    // R7
    mask_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_vamo && wd && !vm && vd == 5'd0) |-> illegal);
    // R5
    vill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && is_vamo && ($past(vill) || !$past(atomic_en))) |-> illegal);
    // R9
    desc_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_vamo |-> (desc[8] == vm) && (desc[11] == wd) && (desc[31:12] == 20'd0));
endmodule

bind vec_atomic_decoder vamo_dec_chk u_chk (.*);

// File: tb/tb_vec_atomic_decoder.sv
// Scoreboard bench: driver pushes expected results, monitor compares them.
module tb_vec_atomic_decoder;
    typedef struct {
        logic        vamo;
        logic        ill;
        logic [3:0]  op;
        logic        dw;
        logic [4:0]  vd, rs1, vs2;
        logic        wd, vm;
        logic [31:0] desc;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] insn = '0;
    logic [1:0]  sew_log2 = 2'd2, lmul_log2 = 2'd0;
    logic        vill = 1'b0, rv64_mode = 1'b1, atomic_en = 1'b1;
    logic        out_valid, is_vamo, illegal, mem_dw, wd, vm;
    logic [3:0]  op_idx;
    logic [4:0]  vd, rs1, vs2;
    logic [31:0] desc;

    int   tests = 0, fails = 0;
    bit   done = 1'b0;
    exp_t sb[$];
    exp_t last_exp;

    always #10 clk = ~clk;

    vec_atomic_decoder dut (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [4:0] f5, input logic w, input logic m,
            input logic [4:0] s2, input logic [4:0] r1, input logic [2:0] wid, input logic [4:0] d);
        return {f5, w, m, s2, r1, wid, d, 7'b0101111};
    endfunction

    // Reference model written from the requirements.
    function automatic exp_t model(input logic [31:0] iw, input logic [1:0] s, input logic [1:0] l,
            input logic vl, input logic r64, input logic ae);
        exp_t e;
        int   grp;
        e = '{vamo:0, ill:0, op:0, dw:0, vd:0, rs1:0, vs2:0, wd:0, vm:0, desc:0};
        case (iw[31:27])
            5'b00001: e.op = 0;  5'b00000: e.op = 1;  5'b00100: e.op = 2;
            5'b01100: e.op = 3;  5'b01000: e.op = 4;  5'b10000: e.op = 5;
            5'b10100: e.op = 6;  5'b11000: e.op = 7;  5'b11100: e.op = 8;
            default:  e.op = 4'hf;
        endcase
        if (iw[6:0] != 7'b0101111 || !(iw[14:12] == 3'b110 || iw[14:12] == 3'b111) || e.op == 4'hf) begin
            e.op = 0;
            return e;
        end
        e.vamo = 1;
        e.dw = (iw[14:12] == 3'b111);
        e.vd = iw[11:7]; e.rs1 = iw[19:15]; e.vs2 = iw[24:20];
        e.vm = iw[25];   e.wd = iw[26];
        grp = 1 << l;
        e.ill = vl || !ae || (s < 2) || (s == 3 && !r64) || (e.dw && !r64) || (e.dw && s == 2)
             || (e.wd && !e.vm && e.vd == 0) || (int'(e.vd) % grp != 0) || (int'(e.vs2) % grp != 0);
        e.desc = {20'd0, e.wd, l, e.vm, 8'((8 << s) >> l)};
        return e;
    endfunction

    task automatic send(input logic [31:0] iw, input logic [1:0] s, input logic [1:0] l,
            input logic vl, input logic r64, input logic ae);
        @(negedge clk);
        insn = iw; sew_log2 = s; lmul_log2 = l; vill = vl; rv64_mode = r64; atomic_en = ae;
        in_valid = 1'b1;
        sb.push_back(model(iw, s, l, vl, r64, ae));
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
            insn = $urandom;
        end
    endtask

    // Monitor: compare each strobed result against the oldest expected item.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                chk(0, "R10 unexpected out_valid", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                last_exp = e;
                chk(is_vamo == e.vamo, "R1 is_vamo", 32'(is_vamo), 32'(e.vamo));
                chk(op_idx == e.op, "R2 op_idx", 32'(op_idx), 32'(e.op));
                chk(mem_dw == e.dw, "R3 mem_dw", 32'(mem_dw), 32'(e.dw));
                chk({vd, rs1, vs2, vm, wd} == {e.vd, e.rs1, e.vs2, e.vm, e.wd}, "R4 fields",
                    32'({vd, rs1, vs2, vm, wd}), 32'({e.vd, e.rs1, e.vs2, e.vm, e.wd}));
                chk(illegal == e.ill, "R5/R6/R7/R8 illegal", 32'(illegal), 32'(e.ill));
                chk(desc == e.desc, "R9 desc", desc, e.desc);
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        logic [4:0] codes [9];
        codes = '{5'b00001, 5'b00000, 5'b00100, 5'b01100, 5'b01000, 5'b10000, 5'b10100, 5'b11000, 5'b11100};
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        chk(out_valid == 0 && is_vamo == 0 && desc == 0 && illegal == 0, "R10 reset", 32'(out_valid), 0);
        rst_n = 1'b1;
        // R1 R2 R4: every operation, 32-bit width, legal configuration, back to back
        for (int k = 0; k < 9; k++)
            send(mk(codes[k], k[0], 1'b1, 5'd3 + 5'(k), 5'(k * 3), 3'b110, 5'd31 - 5'(k)), 2'd2, 2'd0, 0, 1, 1);
        // R3: 64-bit memory width with 64-bit SEW in 64-bit mode
        send(mk(5'b11100, 1, 1, 5'd2, 5'd9, 3'b111, 5'd4), 2'd3, 2'd1, 0, 1, 1);
        // R6 boundaries
        send(mk(5'b00000, 0, 1, 5'd2, 5'd1, 3'b110, 5'd4), 2'd1, 2'd0, 0, 1, 1);
        send(mk(5'b00000, 0, 1, 5'd2, 5'd1, 3'b110, 5'd4), 2'd0, 2'd3, 0, 1, 1);
        send(mk(5'b00000, 0, 1, 5'd2, 5'd1, 3'b110, 5'd4), 2'd3, 2'd0, 0, 0, 1);
        send(mk(5'b00000, 0, 1, 5'd2, 5'd1, 3'b111, 5'd4), 2'd2, 2'd0, 0, 0, 1);
        send(mk(5'b00000, 0, 1, 5'd2, 5'd1, 3'b111, 5'd4), 2'd2, 2'd0, 0, 1, 1);
        send(mk(5'b00000, 0, 1, 5'd2, 5'd1, 3'b110, 5'd4), 2'd3, 2'd0, 0, 1, 1);
        send(mk(5'b00000, 0, 1, 5'd2, 5'd1, 3'b110, 5'd4), 2'd2, 2'd0, 0, 0, 1);
        // R5
        send(mk(5'b00100, 0, 1, 5'd2, 5'd1, 3'b110, 5'd4), 2'd2, 2'd0, 1, 1, 1);
        send(mk(5'b00100, 0, 1, 5'd2, 5'd1, 3'b110, 5'd4), 2'd2, 2'd0, 0, 1, 0);
        // R7 mask overlap
        send(mk(5'b01000, 1, 0, 5'd2, 5'd1, 3'b110, 5'd0), 2'd2, 2'd0, 0, 1, 1);
        send(mk(5'b01000, 1, 1, 5'd2, 5'd1, 3'b110, 5'd0), 2'd2, 2'd0, 0, 1, 1);
        send(mk(5'b01000, 0, 0, 5'd2, 5'd1, 3'b110, 5'd0), 2'd2, 2'd0, 0, 1, 1);
        send(mk(5'b01000, 1, 0, 5'd2, 5'd1, 3'b110, 5'd1), 2'd2, 2'd0, 0, 1, 1);
        idle(2);
        // R8 group alignment at group size 4
        send(mk(5'b10000, 0, 1, 5'd8, 5'd1, 3'b110, 5'd4), 2'd2, 2'd2, 0, 1, 1);
        send(mk(5'b10000, 0, 1, 5'd8, 5'd1, 3'b110, 5'd5), 2'd2, 2'd2, 0, 1, 1);
        send(mk(5'b10000, 0, 1, 5'd6, 5'd1, 3'b110, 5'd4), 2'd2, 2'd2, 0, 1, 1);
        send(mk(5'b10000, 0, 1, 5'd24, 5'd1, 3'b110, 5'd16), 2'd3, 2'd3, 0, 1, 1);
        // R1 near misses
        send(mk(5'b00010, 1, 1, 5'd2, 5'd1, 3'b110, 5'd4), 2'd2, 2'd0, 0, 1, 1);
        send(mk(5'b00001, 1, 1, 5'd2, 5'd1, 3'b010, 5'd4), 2'd2, 2'd0, 0, 1, 1);
        send(mk(5'b00001, 1, 1, 5'd2, 5'd1, 3'b110, 5'd4) ^ 32'h1, 2'd2, 2'd0, 1, 1, 1);
        // R9 descriptor extremes
        send(mk(5'b11000, 1, 1, 5'd0, 5'd7, 3'b111, 5'd0), 2'd3, 2'd0, 0, 1, 1);
        send(mk(5'b11000, 0, 0, 5'd0, 5'd7, 3'b110, 5'd8), 2'd2, 2'd3, 0, 1, 1);
        idle(1);
        // R10 hold: outputs stay at the last result while idle
        idle(3);
        chk(!out_valid, "R10 out_valid low when idle", 32'(out_valid), 0);
        chk(desc == last_exp.desc && illegal == last_exp.ill && op_idx == last_exp.op,
            "R10 hold", desc, last_exp.desc);
        chk(sb.size() == 0, "R10 all results delivered", 32'(sb.size()), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule